// File: doc/BRIEF.md
# Interrupt Redirection Controller with Select/Window Access

This block takes a set of external interrupt lines and turns each event on a line into a message. The message carries a 16-bit destination and an 8-bit vector on a valid/ready handshake. Each line has its own two-word table entry, which holds the vector, the input polarity, edge or level triggering, a mask, and the destination identifiers.

Software reaches the table through only two 32-bit registers. It writes an index into a select register, then reads or writes the chosen word through a data window. A third address takes end-of-interrupt writes, which re-arm level-triggered lines.

A line in edge mode records a pending event when its input changes from inactive to active. A line in level mode sends once and then stays in service until software issues an end-of-interrupt with its vector. When several lines are ready at once, the lowest-numbered line goes first.

Top module: `irq_redirect_ctrl`

## Requirements
- R1: `regAddr` 0 is the select register. Writing it stores `regWrData[7:0]`, and reading it returns that value zero-extended. `regAddr` 1 is the window, which reads and writes the word chosen by the select value. A window write followed by a window read returns the written value with reserved bits cleared.
- R2: Select 0x10+2n is the low word of line n and 0x11+2n is its high word. In the low word, bits 7:0 hold the vector, bit 13 the polarity (1 = active low), bit 15 the trigger (1 = level) and bit 16 the mask (1 = blocked). All other low-word bits read as zero.
- R3: The high word holds the destination id in bits 31:24 and the extended id in bits 23:16. Bits 15:0 read as zero. A message drives `msgDest` = {id, extended id}.
- R4: Select 0x01 reads the constant 0x00NN0011, where NN is NUM_LINES-1 (0x0F by default).
- R5: After reset every entry reads low word 0x00010000 and high word 0, `msgValid` is low, and the select register is 0.
- R6: Select values with no register behind them (including entry indices at or beyond NUM_LINES) read as zero, and window writes to them change nothing. `regAddr` 3 reads zero.
- R7: An edge-mode line sends exactly one message for each inactive-to-active transition of its input, with polarity applied. A line held active sends nothing further.
- R8: A masked line sends nothing, but an edge that arrives while it is masked stays pending. Clearing the mask then sends that message.
- R9: A level-mode line that is active sends one message and then none until a write of its vector to `regAddr` 2 (bits 7:0). After that write it sends again only if the line is still active.
- R10: When several lines are ready together, they are sent in ascending line order, one message per accepted handshake.
- R11: While `msgValid` is high and `msgReady` is low, `msgValid`, `msgDest` and `msgVector` hold. In the cycle after a handshake, `msgValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | 0 select, 1 window, 2 end-of-interrupt, 3 unused |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational on regAddr and select) |
| irqIn | input | NUM_LINES | Interrupt input lines, synchronous to clk |
| msgValid | output | 1 | Message available |
| msgReady | input | 1 | Message accepted by the consumer |
| msgDest | output | 16 | Destination {id, extended id} |
| msgVector | output | 8 | Message vector |

## Verification
On every cycle, the assertions check the handshake rules: held outputs during a stall, the drop after acceptance, and no message without a ready line. They also check that end-of-interrupt clears the in-service state of matching lines, that the select register changes only on its own write, and that low-word writes land in the mask field. Other behaviour can only be shown by the bench's scenarios: the field layout and reserved-bit clearing, the version and unmapped reads, one message per edge under either polarity, pending edges that survive masking, level re-delivery depending on whether the line is still active at end-of-interrupt, and ascending-order delivery. A scoreboard shows these by comparing each message with its expected value and flagging any message that was not expected.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;
  localparam int unsigned IDX_W = 7;
  localparam logic [7:0] SEL_VERSION = 8'h01;
  localparam logic [7:0] SEL_ENTRY_BASE = 8'h10;
  localparam logic [1:0] ADDR_SEL = 2'd0;
  localparam logic [1:0] ADDR_WIN = 2'd1;
  localparam logic [1:0] ADDR_EOI = 2'd2;
  localparam int unsigned BIT_POL = 13;
  localparam int unsigned BIT_TRIG = 15;
  localparam int unsigned BIT_MASK = 16;

  typedef enum logic [2:0] {
    RD_ZERO, RD_SEL, RD_VER, RD_LOW, RD_HIGH
  } rdKindT;

  typedef struct packed {
    logic             lowWr;
    logic             highWr;
    logic             eoiWr;
    logic [IDX_W-1:0] idx;
    logic [31:0]      wdata;
  } busStrobeT;
endpackage

// File: rtl/irq_bus_ctrl.sv
module irq_bus_ctrl
  import irq_redir_pkg::*;
#(
  parameter int unsigned NUM_LINES = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [1:0]  regAddr,
  input  logic [31:0] regWrData,
  output busStrobeT   strobe,
  output rdKindT      rdKind,
  output logic [7:0]  selOut
);
  localparam int unsigned SPAN = 2 * NUM_LINES;

  logic [7:0] selQ;
  logic [7:0] entryOff;
  logic       isEntry;

  always_ff @(posedge clk) begin
    if (!rstN) selQ <= '0;
    else if (regWrEn && regAddr == ADDR_SEL) selQ <= regWrData[7:0];
  end

  assign entryOff = selQ - SEL_ENTRY_BASE;
  assign isEntry  = (selQ >= SEL_ENTRY_BASE) && (32'(entryOff) < SPAN);

  always_comb begin
    strobe.wdata  = regWrData;
    strobe.idx    = entryOff[IDX_W:1];
    strobe.lowWr  = regWrEn && regAddr == ADDR_WIN && isEntry && !entryOff[0];
    strobe.highWr = regWrEn && regAddr == ADDR_WIN && isEntry && entryOff[0];
    strobe.eoiWr  = regWrEn && regAddr == ADDR_EOI;
  end

  always_comb begin
    rdKind = RD_ZERO;
    case (regAddr)
      ADDR_SEL: rdKind = RD_SEL;
      ADDR_WIN: begin
        if (isEntry)                  rdKind = entryOff[0] ? RD_HIGH : RD_LOW;
        else if (selQ == SEL_VERSION) rdKind = RD_VER;
      end
      default: rdKind = RD_ZERO;
    endcase
  end

  assign selOut = selQ;

  // R1
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regAddr == ADDR_SEL) |=> $stable(selQ));
endmodule

// File: rtl/irq_table_dp.sv
module irq_table_dp
  import irq_redir_pkg::*;
#(
  parameter int unsigned NUM_LINES = 16
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  busStrobeT                       strobe,
  input  rdKindT                          rdKind,
  input  logic [7:0]                      selIn,
  output logic [31:0]                     rdData,
  output logic [NUM_LINES-1:0][7:0]       vecTab,
  output logic [NUM_LINES-1:0][15:0]      destTab,
  output logic [NUM_LINES-1:0]            polTab,
  output logic [NUM_LINES-1:0]            trigTab,
  output logic [NUM_LINES-1:0]            maskTab
);
  localparam int unsigned IW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
  localparam logic [31:0] VERSION_WORD = {8'h00, 8'(NUM_LINES - 1), 16'h0011};

  logic [IW-1:0] entIdx;
  assign entIdx = strobe.idx[IW-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecTab  <= '0;
      destTab <= '0;
      polTab  <= '0;
      trigTab <= '0;
      maskTab <= '1;
    end else begin
      if (strobe.lowWr) begin
        vecTab[entIdx]  <= strobe.wdata[7:0];
        polTab[entIdx]  <= strobe.wdata[BIT_POL];
        trigTab[entIdx] <= strobe.wdata[BIT_TRIG];
        maskTab[entIdx] <= strobe.wdata[BIT_MASK];
      end
      if (strobe.highWr) destTab[entIdx] <= strobe.wdata[31:16];
    end
  end

  always_comb begin
    rdData = '0;
    case (rdKind)
      RD_SEL:  rdData = {24'h0, selIn};
      RD_VER:  rdData = VERSION_WORD;
      RD_LOW: begin
        rdData[7:0]      = vecTab[entIdx];
        rdData[BIT_POL]  = polTab[entIdx];
        rdData[BIT_TRIG] = trigTab[entIdx];
        rdData[BIT_MASK] = maskTab[entIdx];
      end
      RD_HIGH: rdData = {destTab[entIdx], 16'h0};
      default: rdData = '0;
    endcase
  end

  // R2
  mask_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.lowWr |=> maskTab[$past(entIdx)] == $past(strobe.wdata[BIT_MASK]));
endmodule

// File: rtl/irq_deliver.sv
module irq_deliver
  import irq_redir_pkg::*;
#(
  parameter int unsigned NUM_LINES = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_LINES-1:0]       irqIn,
  input  logic [NUM_LINES-1:0][7:0]  vecTab,
  input  logic [NUM_LINES-1:0][15:0] destTab,
  input  logic [NUM_LINES-1:0]       polTab,
  input  logic [NUM_LINES-1:0]       trigTab,
  input  logic [NUM_LINES-1:0]       maskTab,
  input  logic                       eoiWr,
  input  logic [7:0]                 eoiVec,
  output logic                       msgValid,
  input  logic                       msgReady,
  output logic [15:0]                msgDest,
  output logic [7:0]                 msgVector
);
  localparam int unsigned IW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

  logic [NUM_LINES-1:0] prevIn, pendQ, inSvcQ;
  logic [NUM_LINES-1:0] riseVec, actVec, reqVec, acceptVec, eoiMatch;
  logic [IW-1:0]        heldIdx, grantIdx;
  logic                 grantFound, accept;

  assign accept = msgValid && msgReady;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    assign actVec[i]    = irqIn[i] ^ polTab[i];
    assign riseVec[i]   = polTab[i] ? (prevIn[i] && !irqIn[i]) : (!prevIn[i] && irqIn[i]);
    assign reqVec[i]    = !maskTab[i] && (trigTab[i] ? (actVec[i] && !inSvcQ[i]) : pendQ[i]);
    assign acceptVec[i] = accept && (heldIdx == IW'(i));
    assign eoiMatch[i]  = eoiWr && trigTab[i] && (vecTab[i] == eoiVec);
  end

  always_comb begin
    grantFound = 1'b0;
    grantIdx   = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (!grantFound && reqVec[i]) begin
        grantFound = 1'b1;
        grantIdx   = IW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevIn <= '0;
      pendQ  <= '0;
      inSvcQ <= '0;
    end else begin
      prevIn <= irqIn;
      pendQ  <= (pendQ & ~(acceptVec & ~trigTab)) | (riseVec & ~trigTab);
      inSvcQ <= ((inSvcQ & ~eoiMatch) | (acceptVec & trigTab)) & trigTab;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      msgValid  <= 1'b0;
      heldIdx   <= '0;
      msgDest   <= '0;
      msgVector <= '0;
    end else if (accept) begin
      msgValid <= 1'b0;
    end else if (!msgValid && grantFound) begin
      msgValid  <= 1'b1;
      heldIdx   <= grantIdx;
      msgDest   <= destTab[grantIdx];
      msgVector <= vecTab[grantIdx];
    end
  end

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !msgReady) |=> (msgValid && $stable(msgDest) && $stable(msgVector)));
  // R11
  drop_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && msgReady) |=> !msgValid);
  // R8
  no_spurious_msg_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(msgValid) |-> $past(|reqVec));
  // R9
  eoi_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    eoiWr |=> ((inSvcQ & $past(eoiMatch & ~acceptVec)) == '0));
endmodule

// File: rtl/irq_redirect_ctrl.sv
module irq_redirect_ctrl
  import irq_redir_pkg::*;
#(
  parameter int unsigned NUM_LINES = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [1:0]           regAddr,
  input  logic [31:0]          regWrData,
  output logic [31:0]          regRdData,
  input  logic [NUM_LINES-1:0] irqIn,
  output logic                 msgValid,
  input  logic                 msgReady,
  output logic [15:0]          msgDest,
  output logic [7:0]           msgVector
);
  busStrobeT                  strobe;
  rdKindT                     rdKind;
  logic [7:0]                 selQ;
  logic [NUM_LINES-1:0][7:0]  vecTab;
  logic [NUM_LINES-1:0][15:0] destTab;
  logic [NUM_LINES-1:0]       polTab, trigTab, maskTab;

  irq_bus_ctrl #(.NUM_LINES(NUM_LINES)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .strobe(strobe), .rdKind(rdKind), .selOut(selQ)
  );

  irq_table_dp #(.NUM_LINES(NUM_LINES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdKind(rdKind), .selIn(selQ),
    .rdData(regRdData), .vecTab(vecTab), .destTab(destTab),
    .polTab(polTab), .trigTab(trigTab), .maskTab(maskTab)
  );

  irq_deliver #(.NUM_LINES(NUM_LINES)) u_dlv (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .vecTab(vecTab), .destTab(destTab),
    .polTab(polTab), .trigTab(trigTab), .maskTab(maskTab),
    .eoiWr(strobe.eoiWr), .eoiVec(strobe.wdata[7:0]),
    .msgValid(msgValid), .msgReady(msgReady), .msgDest(msgDest), .msgVector(msgVector)
  );
endmodule

// File: tb/tb_irq_redirect_ctrl.sv
module tb_irq_redirect_ctrl;
  localparam int unsigned N = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [N-1:0] irqIn = '0;
  logic        msgValid, msgReady = 1'b1;
  logic [15:0] msgDest;
  logic [7:0]  msgVector;

  int nTests = 0;
  int nFail = 0;
  logic [23:0] expQ[$];
  logic [31:0] rd;
  logic [23:0] snap;

  always #4 clk = ~clk;

  irq_redirect_ctrl #(.NUM_LINES(N)) dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .irqIn(irqIn),
    .msgValid(msgValid), .msgReady(msgReady), .msgDest(msgDest), .msgVector(msgVector)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops and compares each accepted message
  always @(negedge clk) begin
    if (rstN && msgValid && msgReady) begin
      if (expQ.size() == 0) check(1'b0, "R7/R8/R9 unexpected message", {8'h0, msgDest, msgVector}, 32'h0);
      else begin
        logic [23:0] e;
        e = expQ.pop_front();
        check({msgDest, msgVector} == e, "R3/R10 message content/order", {8'h0, msgDest, msgVector}, {8'h0, e});
      end
    end
  end

  task automatic busWr(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic busRd(input logic [1:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    regAddr = a;
    @(negedge clk);
    d = regRdData;
  endtask

  task automatic winWr(input logic [7:0] sel, input logic [31:0] d);
    busWr(2'd0, {24'h0, sel});
    busWr(2'd1, d);
  endtask

  task automatic winRd(input logic [7:0] sel, output logic [31:0] d);
    busWr(2'd0, {24'h0, sel});
    busRd(2'd1, d);
  endtask

  task automatic expectMsg(input logic [15:0] dest, input logic [7:0] v);
    expQ.push_back({dest, v});
  endtask

  task automatic pulse(input int line, input int len);
    @(posedge clk); #1; irqIn[line] = ~irqIn[line];
    repeat (len) @(posedge clk);
    #1; irqIn[line] = ~irqIn[line];
  endtask

  task automatic settle(input string req);
    repeat (12) @(posedge clk);
    @(negedge clk);
    check(expQ.size() == 0, req, expQ.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(msgValid == 1'b0, "R5 valid low after reset", msgValid, 0);
    busRd(2'd0, rd);
    check(rd == 0, "R5 select reset", rd, 0);
    winRd(8'h10, rd);
    check(rd == 32'h0001_0000, "R5 low word reset", rd, 32'h0001_0000);
    winRd(8'h2F, rd);
    check(rd == 0, "R5 high word reset", rd, 0);
    winRd(8'h01, rd);
    check(rd == 32'h000F_0011, "R4 version", rd, 32'h000F_0011);
    busRd(2'd0, rd);
    check(rd == 32'h01, "R1 select readback", rd, 32'h01);

    // field layout and reserved bits
    winWr(8'h10 + 2*6, 32'hFFFF_FFFF);
    busRd(2'd1, rd);
    check(rd == 32'h0001_A0FF, "R2 low reserved bits zero", rd, 32'h0001_A0FF);
    winWr(8'h11 + 2*6, 32'hFFFF_FFFF);
    busRd(2'd1, rd);
    check(rd == 32'hFFFF_0000, "R3 high reserved bits zero", rd, 32'hFFFF_0000);
    winWr(8'h10 + 2*6, 32'h0001_0000);
    busRd(2'd1, rd);
    check(rd == 32'h0001_0000, "R1 write then read", rd, 32'h0001_0000);

    // unmapped selects
    winWr(8'h05, 32'hDEAD_BEEF);
    busRd(2'd1, rd);
    check(rd == 0, "R6 unmapped select", rd, 0);
    winWr(8'h30, 32'h1234_5678);
    busRd(2'd1, rd);
    check(rd == 0, "R6 entry beyond line count", rd, 0);
    busRd(2'd3, rd);
    check(rd == 0, "R6 unused address", rd, 0);

    // R7 edge, active high, held long: one message
    winWr(8'h11 + 2*3, 32'hA15B_0000);
    winWr(8'h10 + 2*3, 32'h0000_0033);
    expectMsg(16'hA15B, 8'h33);
    pulse(3, 6);
    settle("R7 edge high single message");

    // R7 active-low edge
    winWr(8'h11 + 2*5, 32'h0505_0000);
    winWr(8'h10 + 2*5, 32'h0000_2055);
    @(posedge clk); #1 irqIn[5] = 1'b1;
    repeat (3) @(posedge clk);
    expectMsg(16'h0505, 8'h55);
    #1 irqIn[5] = 1'b0;
    settle("R7 active-low edge");
    @(posedge clk); #1 irqIn[5] = 1'b1;
    settle("R7 inactive transition sends nothing");

    // R8 masked pending kept
    winWr(8'h11 + 2*7, 32'h7777_0000);
    winWr(8'h10 + 2*7, 32'h0001_0077);
    pulse(7, 2);
    repeat (10) @(posedge clk);
    @(negedge clk);
    check(msgValid == 0, "R8 masked sends nothing", msgValid, 0);
    expectMsg(16'h7777, 8'h77);
    winWr(8'h10 + 2*7, 32'h0000_0077);
    settle("R8 unmask releases pending");

    // R10 priority
    winWr(8'h11 + 2*2, 32'h0202_0000);
    winWr(8'h10 + 2*2, 32'h0000_0022);
    winWr(8'h11 + 2*9, 32'h0909_0000);
    winWr(8'h10 + 2*9, 32'h0000_0099);
    expectMsg(16'h0202, 8'h22);
    expectMsg(16'h0909, 8'h99);
    @(posedge clk); #1 irqIn[2] = 1'b1; irqIn[9] = 1'b1;
    @(posedge clk); #1 irqIn[2] = 1'b0; irqIn[9] = 1'b0;
    settle("R10 ascending order");

    // R9 level
    winWr(8'h11 + 2*4, 32'h7E2C_0000);
    winWr(8'h10 + 2*4, 32'h0000_8044);
    expectMsg(16'h7E2C, 8'h44);
    @(posedge clk); #1 irqIn[4] = 1'b1;
    settle("R9 level first message");
    @(negedge clk);
    check(msgValid == 0, "R9 no repeat before EOI", msgValid, 0);
    expectMsg(16'h7E2C, 8'h44);
    busWr(2'd2, 32'h44);
    settle("R9 EOI re-delivers active line");
    @(posedge clk); #1 irqIn[4] = 1'b0;
    busWr(2'd2, 32'h44);
    settle("R9 EOI with inactive line sends nothing");
    @(negedge clk);
    check(msgValid == 0, "R9 idle after EOI", msgValid, 0);

    // R11 backpressure
    @(posedge clk); #1 msgReady = 1'b0;
    pulse(3, 2);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(msgValid == 1, "R11 valid under stall", msgValid, 1);
    snap = {msgDest, msgVector};
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(msgValid == 1 && {msgDest, msgVector} == snap, "R11 hold under stall",
          {8'h0, msgDest, msgVector}, {8'h0, snap});
    expectMsg(16'hA15B, 8'h33);
    @(posedge clk); #1 msgReady = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(msgValid == 0, "R11 valid drops after accept", msgValid, 0);
    settle("R11 stalled message delivered");

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule